// File: doc/BRIEF.md
# Signed Integer Divider with Division Exception Control

This unit performs 32-bit two's-complement division for an execute stage. A one-cycle `start` pulse hands it a dividend and a divisor. An ordinary divide runs 32 restoring shift-subtract steps on the operand magnitudes, one quotient bit per clock. The quotient is negated at the end when the operand signs differ, so the result truncates toward zero. A single-cycle `done` pulse marks the cycle in which the result and the exception outputs become valid. `wr_en` tells the register file whether to write the destination.

Two operand pairs are caught when `start` is accepted and take no iterations. One is the most-negative value divided by minus one. The other is any dividend divided by zero. The overflow case depends on the `mask_exc` input. With `mask_exc` set, the unit saturates the result and sets a sticky accrued-exception flag. With it clear, the unit traps and still writes the destination. A zero divisor always traps and never writes. Each trap reports a two-bit trap type and loads an error record that holds a valid bit and a fixed error code.

The controller has two states. ST_IDLE waits for `start`. It returns to itself after a one-cycle corner-case finish and moves to ST_RUN when an ordinary divide is loaded. ST_RUN performs one iteration per clock. It returns to ST_IDLE on the iteration numbered 31, counting from 0, which is the last one.

Top module: `sdiv_unit`

## Requirements
- R1: An ordinary divide accepted at clock edge T drives `done` and `wr_en` high for one cycle after edge T+32. `quotient` then holds the signed quotient truncated toward zero. Examples: 12/3 = 4, 0xFEDCBA98/0x01234567 = 0xFFFFFFFF, -7/2 = -3.
- R2: `busy` is high from the cycle after an ordinary `start` until the edge on which `done` rises. While `busy` is high, a `start` is ignored, whatever operands come with it.
- R3: When `mask_exc` is 1, 0x80000000 / 0xFFFFFFFF pulses `done` and `wr_en` in the cycle after the start edge. `quotient` is 0x7FFFFFFF, `trap` stays 0, the trap type is 0 and the accrued flag is set.
- R4: When `mask_exc` is 0, 0x80000000 / 0xFFFFFFFF pulses `done`, `wr_en` and `trap` in the cycle after the start edge. The trap type is 2 and `quotient` is 0x80000000.
- R5: A zero divisor pulses `done` and `trap` in the cycle after the start edge, whatever the value of `mask_exc`. The trap type is 3, `wr_en` stays 0 and `quotient` keeps its previous value.
- R6: `err_word` is updated at every `done`. On a trap, bit 0 is 1 and bits 5:1 hold 0x13, giving 0x27. On a completion without a trap, `err_word` is 0.
- R7: `stat_word` has the following layout. Bit 5 is the live `mask_exc` input, bits 4:3 are the trap type of the last completion, bit 2 is the accrued flag and bits 1:0 are 0.
- R8: Once set, the accrued flag stays set through later ordinary divides and traps. It is cleared only when `clr_accrued` is high at a clock edge. If `clr_accrued` is high on the same edge as a masked overflow, the flag is set.
- R9: A synchronous active-high `rst` clears `busy`, `done`, `wr_en`, `trap`, the trap type, the error record, the accrued flag and `quotient`. This includes a reset applied in the middle of a divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide (ignored while busy) |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Signed divisor |
| mask_exc | input | 1 | 1: saturate overflow and accrue; 0: trap on overflow |
| clr_accrued | input | 1 | Clear the sticky accrued flag |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Destination value |
| wr_en | output | 1 | Destination write enable, pulsed with done |
| trap | output | 1 | One-cycle division trap pulse |
| err_word | output | 6 | Error record: bit 0 valid, bits 5:1 code |
| stat_word | output | 6 | Status: bit 5 mask, 4:3 trap type, 2 accrued |

## Verification
The divide is tried with the four sign combinations of the operands. Mixed signs show whether the final negation is applied correctly and whether the result truncates toward zero rather than flooring. The magnitude cases are small exact quotients, a quotient of -1 from large unequal operands, and the extreme values 0x80000000/1 and 0x7FFFFFFF/-1. These distinguish an error in the final iteration from an error in the absolute-value stage. The overflow pair is issued with each setting of the mask, and the zero divisor is issued with both settings and a known prior quotient. Together these show the write and trap behaviour and confirm that the zero divisor leaves the destination alone. A start with different operands in the middle of a divide, and a reset in the middle of a divide, show that the busy window is protected and that reset returns the unit to idle.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } sdiv_state_t;

    typedef enum logic [2:0] {
        FIN_NONE,
        FIN_NORMAL,
        FIN_SAT,
        FIN_OVF_TRAP,
        FIN_ZERO_TRAP
    } sdiv_fin_t;

    localparam logic [1:0] TT_NONE = 2'd0;
    localparam logic [1:0] TT_OVF  = 2'd2;
    localparam logic [1:0] TT_ZERO = 2'd3;

endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         is_zero,
    output logic         is_ovf,
    output logic [W-1:0] q_final
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic         neg_q;
    logic [W:0]   shifted, diff;
    logic         ge;
    logic [W-1:0] nrem, nquo;
    logic [W-1:0] a_abs, b_abs;

    // corner-case classification on the raw operands
    always_comb begin
        is_zero = (divisor == '0);
        is_ovf  = (dividend == MINV) && (divisor == '1);
        a_abs   = dividend[W-1] ? (~dividend + 1'b1) : dividend;
        b_abs   = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    end

    // one restoring step: shift in the next dividend bit, try subtract
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        ge      = ~diff[W];
        nrem    = ge ? diff[W-1:0] : shifted[W-1:0];
        nquo    = {quo_q[W-2:0], ge};
        q_final = neg_q ? (~nquo + 1'b1) : nquo;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q <= '0;
            quo_q <= a_abs;
            dvs_q <= b_abs;
            neg_q <= dividend[W-1] ^ divisor[W-1];
        end else if (step) begin
            rem_q <= nrem;
            quo_q <= nquo;
        end
    end

endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      is_zero,
    input  logic      is_ovf,
    input  logic      mask_exc,
    output logic      busy,
    output logic      load,
    output logic      step,
    output sdiv_fin_t fin
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    sdiv_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(W - 1));
    assign busy = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        fin     = FIN_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (is_zero)     fin = FIN_ZERO_TRAP;
                    else if (is_ovf) fin = mask_exc ? FIN_SAT : FIN_OVF_TRAP;
                    else begin
                        load    = 1'b1;
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                step = 1'b1;
                if (last) begin
                    fin     = FIN_NORMAL;
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load) cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    // R2
    run_count_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);

endmodule

// File: rtl/sdiv_status.sv
module sdiv_status
    import sdiv_pkg::*;
#(
    parameter int         W        = 32,
    parameter logic [4:0] ERR_CODE = 5'h13
) (
    input  logic         clk,
    input  logic         rst,
    input  sdiv_fin_t    fin,
    input  logic [W-1:0] q_final,
    input  logic         clr_acc,
    output logic [W-1:0] quotient,
    output logic         wr_en,
    output logic         done,
    output logic         trap,
    output logic [1:0]   trap_type,
    output logic         err_valid,
    output logic [4:0]   err_code,
    output logic         accrued
);
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SATV = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            quotient  <= '0;
            wr_en     <= 1'b0;
            done      <= 1'b0;
            trap      <= 1'b0;
            trap_type <= TT_NONE;
            err_valid <= 1'b0;
            err_code  <= '0;
        end else begin
            done  <= (fin != FIN_NONE);
            wr_en <= 1'b0;
            trap  <= 1'b0;
            unique case (fin)
                FIN_NONE: ;
                FIN_NORMAL, FIN_SAT: begin
                    quotient  <= (fin == FIN_SAT) ? SATV : q_final;
                    wr_en     <= 1'b1;
                    trap_type <= TT_NONE;
                    err_valid <= 1'b0;
                    err_code  <= '0;
                end
                FIN_OVF_TRAP: begin
                    quotient  <= MINV;
                    wr_en     <= 1'b1;
                    trap      <= 1'b1;
                    trap_type <= TT_OVF;
                    err_valid <= 1'b1;
                    err_code  <= ERR_CODE;
                end
                FIN_ZERO_TRAP: begin
                    trap      <= 1'b1;
                    trap_type <= TT_ZERO;
                    err_valid <= 1'b1;
                    err_code  <= ERR_CODE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 accrued <= 1'b0;
        else if (fin == FIN_SAT) accrued <= 1'b1;
        else if (clr_acc)        accrued <= 1'b0;
    end

    // R8
    accrued_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (accrued && !clr_acc) |=> accrued);

    // R5
    zero_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (trap && trap_type == TT_ZERO) |-> !wr_en);

    // R4
    ovf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (trap && trap_type == TT_OVF) |-> (wr_en && quotient == MINV));

    // R6
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        trap |-> (err_valid && err_code == ERR_CODE));

    // R3
    sat_value_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !trap && $rose(accrued)) |-> (wr_en && quotient == SATV));

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int         W        = 32,
    parameter logic [4:0] ERR_CODE = 5'h13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         mask_exc,
    input  logic         clr_accrued,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         wr_en,
    output logic         trap,
    output logic [5:0]   err_word,
    output logic [5:0]   stat_word
);
    logic         is_zero, is_ovf, load, step;
    logic [W-1:0] q_final;
    sdiv_fin_t    fin;
    logic [1:0]   trap_type;
    logic         err_valid, accrued;
    logic [4:0]   err_code;

    sdiv_core #(.W(W)) u_core (
        .clk      (clk),
        .load     (load),
        .step     (step),
        .dividend (dividend),
        .divisor  (divisor),
        .is_zero  (is_zero),
        .is_ovf   (is_ovf),
        .q_final  (q_final)
    );

    sdiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_zero  (is_zero),
        .is_ovf   (is_ovf),
        .mask_exc (mask_exc),
        .busy     (busy),
        .load     (load),
        .step     (step),
        .fin      (fin)
    );

    sdiv_status #(.W(W), .ERR_CODE(ERR_CODE)) u_status (
        .clk       (clk),
        .rst       (rst),
        .fin       (fin),
        .q_final   (q_final),
        .clr_acc   (clr_accrued),
        .quotient  (quotient),
        .wr_en     (wr_en),
        .done      (done),
        .trap      (trap),
        .trap_type (trap_type),
        .err_valid (err_valid),
        .err_code  (err_code),
        .accrued   (accrued)
    );

    assign err_word  = {err_code, err_valid};
    assign stat_word = {mask_exc, trap_type, accrued, 2'b00};

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R1
    write_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done);

endmodule

// File: tb/sdiv_unit_test.sv
`timescale 1ns/1ps
module sdiv_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        mask_exc = 1'b0;
    logic        clr_accrued = 1'b0;
    logic        busy, done, wr_en, trap;
    logic [31:0] quotient;
    logic [5:0]  err_word, stat_word;

    always #10 clk = ~clk;   // 50 MHz

    sdiv_unit uut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .mask_exc(mask_exc), .clr_accrued(clr_accrued),
        .busy(busy), .done(done), .quotient(quotient), .wr_en(wr_en),
        .trap(trap), .err_word(err_word), .stat_word(stat_word)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_done, m_wr, m_trap, m_ev, m_acc, m_set, started;
    int          m_cnt;
    logic [1:0]  m_tt;
    logic [31:0] m_q, m_pend;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_done = 0; m_wr = 0; m_trap = 0;
            m_tt = 0; m_ev = 0; m_acc = 0; m_q = 0;
        end else begin
            m_done = 0; m_wr = 0; m_trap = 0; m_set = 0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_wr = 1; m_q = m_pend;
                    m_tt = 0; m_ev = 0;
                end
            end else if (start) begin
                if (divisor == 0) begin
                    m_done = 1; m_trap = 1; m_tt = 3; m_ev = 1;
                end else if (dividend == 32'h8000_0000 && divisor == 32'hFFFF_FFFF) begin
                    m_done = 1; m_wr = 1;
                    if (mask_exc) begin
                        m_q = 32'h7FFF_FFFF; m_tt = 0; m_ev = 0; m_set = 1;
                    end else begin
                        m_q = 32'h8000_0000; m_trap = 1; m_tt = 2; m_ev = 1;
                    end
                end else begin
                    m_busy = 1; m_cnt = 32;
                    m_pend = 32'($signed(dividend) / $signed(divisor));
                end
            end
            if (m_set) m_acc = 1;
            else if (clr_accrued) m_acc = 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compared every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2", "busy", 32'(busy), 32'(m_busy));
            chk("R1", "done", 32'(done), 32'(m_done));
            chk("R5", "wr_en", 32'(wr_en), 32'(m_wr));
            chk("R4", "trap", 32'(trap), 32'(m_trap));
            chk("R1", "quotient", quotient, m_q);
            chk("R6", "err_word", 32'(err_word), m_ev ? 32'h27 : 32'h0);
            chk("R7", "stat_word", 32'(stat_word),
                32'({mask_exc, m_tt, m_acc, 2'b00}));
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic m);
        dividend = a; divisor = b; mask_exc = m; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40 && !done; i++) tick();
    endtask

    task automatic divide(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp, input string req);
        issue(a, b, 1'b0);
        wait_done();
        chk(req, "directed quotient", quotient, exp);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R9 reset state
        chk("R9", "reset busy", 32'(busy), 0);
        chk("R9", "reset stat", 32'(stat_word), 0);
        chk("R9", "reset err", 32'(err_word), 0);

        // R1 ordinary divides, timing of done
        issue(32'd12, 32'd3, 1'b0);
        repeat (31) tick();
        chk("R1", "done not yet", 32'(done), 0);
        tick();
        chk("R1", "done after 32", 32'(done), 1);
        chk("R1", "12/3", quotient, 32'd4);
        divide(32'hFEDC_BA98, 32'h0123_4567, 32'hFFFF_FFFF, "R1");
        divide(-32'sd7, 32'd2, -32'sd3, "R1");
        divide(32'd7, -32'sd2, -32'sd3, "R1");
        divide(-32'sd100, -32'sd7, 32'd14, "R1");
        divide(32'h8000_0000, 32'd1, 32'h8000_0000, "R1");
        divide(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001, "R1");

        // R2 start while busy is ignored
        issue(32'd1000, 32'd10, 1'b0);
        tick();
        chk("R2", "busy during run", 32'(busy), 1);
        issue(32'd9, 32'd0, 1'b0);
        issue(32'd50, 32'd5, 1'b0);
        wait_done();
        chk("R2", "ignored start result", quotient, 32'd100);
        chk("R2", "no trap from ignored start", 32'(trap), 0);

        // R3 masked overflow saturates
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        chk("R3", "sat done", 32'(done), 1);
        chk("R3", "sat quotient", quotient, 32'h7FFF_FFFF);
        chk("R3", "sat stat", 32'(stat_word), 32'h24);
        // R8 sticky through a normal divide
        divide(32'd20, 32'd4, 32'd5, "R8");
        chk("R8", "accrued kept", 32'(stat_word[2]), 1);
        clr_accrued = 1'b1;
        tick();
        clr_accrued = 1'b0;
        chk("R8", "accrued cleared", 32'(stat_word[2]), 0);
        // R8 set wins over simultaneous clear
        clr_accrued = 1'b1;
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        clr_accrued = 1'b0;
        chk("R8", "set beats clear", 32'(stat_word[2]), 1);

        // R4 unmasked overflow traps and writes
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        chk("R4", "ovf trap", 32'(trap), 1);
        chk("R4", "ovf wr", 32'(wr_en), 1);
        chk("R4", "ovf quotient", quotient, 32'h8000_0000);
        chk("R6", "ovf err", 32'(err_word), 32'h27);
        chk("R7", "ovf stat", 32'(stat_word), 32'h14);

        // R5 divide by zero, both mask settings, quotient kept
        divide(32'd77, 32'd7, 32'd11, "R5");
        issue(32'd5, 32'd0, 1'b0);
        chk("R5", "zero trap", 32'(trap), 1);
        chk("R5", "zero no write", 32'(wr_en), 0);
        chk("R5", "zero keeps quotient", quotient, 32'd11);
        issue(32'h8000_0000, 32'd0, 1'b1);
        chk("R5", "zero masked trap", 32'(trap), 1);
        chk("R7", "zero stat", 32'(stat_word), 32'h3C);
        divide(32'd9, 32'd3, 32'd3, "R6");
        chk("R6", "err cleared on normal", 32'(err_word), 0);

        // R9 reset mid-run
        issue(32'd400, 32'd4, 1'b0);
        repeat (5) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9", "busy after reset", 32'(busy), 0);
        chk("R9", "quotient after reset", quotient, 0);
        chk("R9", "stat after reset", 32'(stat_word), 0);
        repeat (40) tick();
        chk("R9", "no late done", 32'(done), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule